// File: doc/BRIEF.md
# Branch Target Buffer

This block predicts, during instruction fetch, whether the instruction at the current fetch address is a taken branch, and where it goes. It is a direct-mapped table. The word-address bits just above the byte offset select one slot. The rest of the upper address bits are compared with a tag held in that slot. A valid slot whose tag matches is a hit. The block then reports a taken prediction and presents the stored destination as the next fetch address, in the same cycle as the lookup, so a correctly predicted taken branch costs no bubble. On a miss the block predicts not taken and presents the sequential address, fetch address plus four.

Only branches currently believed taken live in the table. Each slot carries a 2-bit confidence counter next to its destination. The resolve stage reports every executed branch on a separate port. A taken branch that missed claims its slot. A branch that hit moves its counter. A slot whose counter falls below the weakly-taken level is dropped, so that address misses again.

Top module: `tpb_top`

## Requirements
- R1: Reset (synchronous, active high) invalidates every slot, so after reset every fetch address predicts not taken.
- R2: On a miss, `pred_taken` is 0 and `next_pc` is `fetch_pc + 4` (modulo 2^32), in the same cycle as the lookup.
- R3: A resolved taken branch that misses is written into its slot. From the next cycle, fetching that address gives `pred_taken` = 1 and `next_pc` equal to the resolved destination.
- R4: The slot is chosen by `fetch_pc[5:2]` (16 slots), and the tag is `fetch_pc[31:6]`. An address that shares the slot but differs in the tag misses.
- R5: `fetch_pc[1:0]` takes no part in indexing or tag comparison.
- R6: Counter encoding is 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken. A new slot starts at 2. A taken hit counts up and saturates at 3. A not-taken hit counts down. A slot whose counter would drop below 2 is invalidated.
- R7: A resolved not-taken branch that misses changes nothing in the table, including another branch already held in that slot.
- R8: A resolved taken miss in a slot held by a different branch replaces that branch. The old address then misses.
- R9: A resolved taken hit replaces the stored destination with the newly resolved one.
- R10: When a resolve and a lookup touch the same slot in one cycle, the lookup sees the contents from before the write. The write is visible from the next cycle.
- R11: Slots at different indices are independent. A write to one slot leaves the prediction for every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | output | 1 | Lookup hit: branch predicted taken |
| next_pc | output | 32 | Predicted next fetch address |
| rslv_en | input | 1 | A branch outcome is reported this cycle |
| rslv_pc | input | 32 | Address of the resolved branch |
| rslv_taken | input | 1 | Resolved direction, 1 = taken |
| rslv_target | input | 32 | Resolved destination of the branch |

## Verification
A wrong tag, a wrong destination or a stale valid bit shows up at once: it gives a wrong `pred_taken` or `next_pc` for any fetch of that slot from the cycle after the faulty write. A wrong counter is hidden until later. It only shows when a later not-taken outcome drops, or fails to drop, the slot, so the stimulus runs taken and not-taken outcomes in sequence and then fetches the same address. A write that lands one cycle early or late, or in a neighbouring slot, shows on a fetch issued in the same cycle as a resolve and on fetches of neighbouring slots.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

    parameter int PC_W       = 32;
    parameter int IDX_W      = 4;
    parameter int OFS_W      = 2;
    parameter int INSN_BYTES = 4;

    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W - OFS_W;

    typedef enum logic [1:0] {
        CONF_STRONG_NT = 2'd0,
        CONF_WEAK_NT   = 2'd1,
        CONF_WEAK_T    = 2'd2,
        CONF_STRONG_T  = 2'd3
    } conf_e;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  dest;
        conf_e            conf;
    } slot_t;

    function automatic logic [IDX_W-1:0] slot_of(input logic [PC_W-1:0] pc);
        return pc[OFS_W +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

    function automatic conf_e conf_up(input conf_e c);
        return (c == CONF_STRONG_T) ? CONF_STRONG_T : conf_e'(c + 2'd1);
    endfunction

    function automatic conf_e conf_down(input conf_e c);
        return (c == CONF_STRONG_NT) ? CONF_STRONG_NT : conf_e'(c - 2'd1);
    endfunction

endpackage

// File: rtl/tpb_store.sv
module tpb_store
    import tpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] fetch_idx,
    output slot_t            fetch_slot,
    input  logic [IDX_W-1:0] rslv_idx,
    output slot_t            rslv_slot,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_t            wr_slot
);

    slot_t             slots [DEPTH];
    logic [DEPTH-1:0]  live;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slots[g] <= wr_slot;
            end
        end
        assign live[g] = slots[g].valid;
    end

    assign fetch_slot = slots[fetch_idx];
    assign rslv_slot  = slots[rslv_idx];

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (live == '0));

    // R10
    write_land_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) && !$past(rst) |-> (slots[$past(wr_idx)] == $past(wr_slot)));

endmodule

// File: rtl/tpb_fetch.sv
module tpb_fetch
    import tpb_pkg::*;
(
    input  logic [PC_W-1:0] fetch_pc,
    input  slot_t           slot,
    output logic            hit,
    output logic [PC_W-1:0] next_pc
);

    logic [PC_W-1:0] seq_pc;

    assign seq_pc  = fetch_pc + PC_W'(INSN_BYTES);
    assign hit     = slot.valid && (slot.tag == tag_of(fetch_pc));
    assign next_pc = hit ? slot.dest : seq_pc;

endmodule

// File: rtl/tpb_resolve.sv
module tpb_resolve
    import tpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rslv_en,
    input  logic [PC_W-1:0]  rslv_pc,
    input  logic             rslv_taken,
    input  logic [PC_W-1:0]  rslv_target,
    input  slot_t            cur_slot,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output slot_t            wr_slot
);

    logic  known;
    conf_e lowered;

    assign known   = cur_slot.valid && (cur_slot.tag == tag_of(rslv_pc));
    assign lowered = conf_down(cur_slot.conf);
    assign wr_idx  = slot_of(rslv_pc);

    always_comb begin
        wr_en   = 1'b0;
        wr_slot = cur_slot;
        if (rslv_en) begin
            if (known) begin
                wr_en = 1'b1;
                if (rslv_taken) begin
                    wr_slot.conf = conf_up(cur_slot.conf);
                    wr_slot.dest = rslv_target;
                end else begin
                    wr_slot.conf  = lowered;
                    wr_slot.valid = (lowered >= CONF_WEAK_T);
                end
            end else if (rslv_taken) begin
                wr_en         = 1'b1;
                wr_slot.valid = 1'b1;
                wr_slot.tag   = tag_of(rslv_pc);
                wr_slot.dest  = rslv_target;
                wr_slot.conf  = CONF_WEAK_T;
            end
        end
    end

    // R3
    taken_writes_chk: assert property (@(posedge clk) disable iff (rst)
        rslv_en && rslv_taken |-> wr_en && wr_slot.valid);

    // R6
    conf_floor_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_slot.valid |-> (wr_slot.conf >= CONF_WEAK_T));

    // R7
    nt_miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rslv_en && !rslv_taken && !known |-> !wr_en);

    // R8
    alloc_tag_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && !known |-> (wr_slot.tag == tag_of(rslv_pc)) && (wr_slot.conf == CONF_WEAK_T));

endmodule

// File: rtl/tpb_top.sv
module tpb_top
    import tpb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     fetch_pc,
    output logic            pred_taken,
    output logic [31:0]     next_pc,
    input  logic            rslv_en,
    input  logic [31:0]     rslv_pc,
    input  logic            rslv_taken,
    input  logic [31:0]     rslv_target
);

    slot_t            fetch_slot;
    slot_t            rslv_slot;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    slot_t            wr_slot;

    tpb_store u_store (
        .clk        (clk),
        .rst        (rst),
        .fetch_idx  (slot_of(fetch_pc)),
        .fetch_slot (fetch_slot),
        .rslv_idx   (slot_of(rslv_pc)),
        .rslv_slot  (rslv_slot),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_slot    (wr_slot)
    );

    tpb_fetch u_fetch (
        .fetch_pc (fetch_pc),
        .slot     (fetch_slot),
        .hit      (pred_taken),
        .next_pc  (next_pc)
    );

    tpb_resolve u_resolve (
        .clk         (clk),
        .rst         (rst),
        .rslv_en     (rslv_en),
        .rslv_pc     (rslv_pc),
        .rslv_taken  (rslv_taken),
        .rslv_target (rslv_target),
        .cur_slot    (rslv_slot),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_slot     (wr_slot)
    );

    // R11
    other_slot_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) && !$past(rst) && (slot_of(fetch_pc) != $past(wr_idx))
            && $stable(fetch_pc) |-> $stable(next_pc));

endmodule

// File: tb/tb_tpb_top.sv
module tb_tpb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = 32'h0;
    logic        pred_taken;
    logic [31:0] next_pc;
    logic        rslv_en = 1'b0;
    logic [31:0] rslv_pc = 32'h0;
    logic        rslv_taken = 1'b0;
    logic [31:0] rslv_target = 32'h0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tpb_top dut (
        .clk         (clk),
        .rst         (rst),
        .fetch_pc    (fetch_pc),
        .pred_taken  (pred_taken),
        .next_pc     (next_pc),
        .rslv_en     (rslv_en),
        .rslv_pc     (rslv_pc),
        .rslv_taken  (rslv_taken),
        .rslv_target (rslv_target)
    );

    typedef struct packed {
        logic        ren;
        logic [31:0] rpc;
        logic        rtk;
        logic [31:0] rtgt;
        logic [31:0] fpc;
        logic        ehit;
        logic [31:0] enext;
        logic [7:0]  req;
    } vec_t;

    // A=0x1000 (slot 0), A2=0x2000 (slot 0), B=0x1008 (slot 2), B2=0x2008 (slot 2), C=0x1004 (slot 1)
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1000, 1'b0, 32'h1004, 8'd2 },  // R2 empty miss
        '{1'b1, 32'h1000,   1'b1, 32'h4000, 32'h1000, 1'b0, 32'h1004, 8'd10},  // R10 old contents
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1000, 1'b1, 32'h4000, 8'd3 },  // R3 allocated
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1002, 1'b1, 32'h4000, 8'd5 },  // R5 low bits
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h2000, 1'b0, 32'h2004, 8'd4 },  // R4 alias
        '{1'b1, 32'h2000,   1'b0, 32'h9999, 32'h1000, 1'b1, 32'h4000, 8'd7 },  // R7
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1000, 1'b1, 32'h4000, 8'd7 },  // R7 untouched
        '{1'b1, 32'h1008,   1'b1, 32'h5000, 32'h1000, 1'b1, 32'h4000, 8'd11},  // R11
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1008, 1'b1, 32'h5000, 8'd11},  // R11
        '{1'b1, 32'h1000,   1'b1, 32'h4400, 32'h1008, 1'b1, 32'h5000, 8'd11},  // R11
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1000, 1'b1, 32'h4400, 8'd9 },  // R9 new dest
        '{1'b1, 32'h1000,   1'b0, 32'h0,    32'h1000, 1'b1, 32'h4400, 8'd10},  // R10
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1000, 1'b1, 32'h4400, 8'd6 },  // R6 3->2 stays
        '{1'b1, 32'h1000,   1'b0, 32'h0,    32'h1008, 1'b1, 32'h5000, 8'd11},  // R11
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1000, 1'b0, 32'h1004, 8'd6 },  // R6 2->1 drops
        '{1'b1, 32'h2000,   1'b1, 32'h6000, 32'h1000, 1'b0, 32'h1004, 8'd6 },  // R6
        '{1'b1, 32'h2008,   1'b1, 32'h7000, 32'h2000, 1'b1, 32'h6000, 8'd3 },  // R3
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h1008, 1'b0, 32'h100C, 8'd8 },  // R8 evicted
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h2008, 1'b1, 32'h7000, 8'd8 },  // R8 new owner
        '{1'b1, 32'h2008,   1'b0, 32'h0,    32'h1004, 1'b0, 32'h1008, 8'd11},  // R11
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h2008, 1'b0, 32'h200C, 8'd6 },  // R6 drop
        '{1'b0, 32'h0,      1'b0, 32'h0,    32'h2000, 1'b1, 32'h6000, 8'd11}   // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(input string req, input logic [31:0] pc, input logic ehit,
                        input logic [31:0] enext);
        @(negedge clk);
        rslv_en  = 1'b0;
        fetch_pc = pc;
        #1;
        check(req, {31'h0, pred_taken}, {31'h0, ehit});
        check(req, next_pc, enext);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 nothing predicted after reset
        look("R1", 32'h1000, 1'b0, 32'h1004);
        look("R1", 32'hABCD_0008, 1'b0, 32'hABCD_000C);
        // R2 sequential wraps modulo 2^32
        look("R2", 32'hFFFF_FFFC, 1'b0, 32'h0000_0000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rslv_en     = VECS[i].ren;
            rslv_pc     = VECS[i].rpc;
            rslv_taken  = VECS[i].rtk;
            rslv_target = VECS[i].rtgt;
            fetch_pc    = VECS[i].fpc;
            #1;
            check($sformatf("R%0d row %0d", VECS[i].req, i), {31'h0, pred_taken}, {31'h0, VECS[i].ehit});
            check($sformatf("R%0d row %0d", VECS[i].req, i), next_pc, VECS[i].enext);
        end

        // R9 then R6: taken hit to strong, two not-taken hits to drop
        @(negedge clk);
        rslv_en = 1'b1; rslv_pc = 32'h1010; rslv_taken = 1'b1; rslv_target = 32'h8000;
        @(negedge clk);
        rslv_target = 32'h8800;
        @(negedge clk);
        rslv_taken = 1'b0;
        look("R9", 32'h1010, 1'b1, 32'h8800);
        @(negedge clk);
        rslv_en = 1'b1; rslv_pc = 32'h1010; rslv_taken = 1'b0;
        look("R6", 32'h1010, 1'b0, 32'h1014);

        // R1 reset in the middle clears live slots
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        look("R1", 32'h2000, 1'b0, 32'h2004);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule